// File: doc/BRIEF.md
# Branch History Table Predictor

This block guesses the next instruction fetch address for a pipelined fetch unit. Each cycle the fetch stage presents the address it is fetching. The block looks that address up in a small direct-mapped table. Each entry holds a valid bit, an address tag, the last taken-branch target and a 2-bit saturating confidence counter. If the lookup misses, or the entry leans toward not taken, the next fetch address is the current address plus 4. If the entry leans toward taken, the next fetch address is the stored target.

When a branch finishes executing, the back end sends a resolve bundle. The bundle carries the branch address, the actual direction, the actual target and the direction that was predicted for it. The block trains or allocates the matching entry. If the actual direction differs from the predicted one, the block raises a one-cycle flush pulse one clock later. With the pulse it gives the correct restart address, so the fetch unit can discard younger work and redirect.

Top module: `bht_predictor`

## Requirements
- R1: After reset every entry is invalid. Every lookup then gives `pred_taken`=0 and `next_fetch_addr`=`fetch_addr`+4, and `flush` is 0.
- R2: A lookup misses when the entry at index `fetch_addr[IDXW+1:2]` is invalid, or when its tag differs from `fetch_addr[AW-1:IDXW+2]`. A missing lookup gives `pred_taken`=0 and `next_fetch_addr`=`fetch_addr`+4, in the same cycle.
- R3: A hitting lookup whose counter is 2 or 3 gives `pred_taken`=1 and `next_fetch_addr`= the stored target. A hitting lookup whose counter is 0 or 1 gives `pred_taken`=0 and `fetch_addr`+4.
- R4: A resolve that hits its entry moves the counter up by one when taken and down by one when not taken. The counter saturates at 3 and at 0.
- R5: A taken resolve that misses allocates its entry. It writes the valid bit, the tag, the target and counter value 2 (binary 10), replacing any entry already at that index.
- R6: A not-taken resolve that misses leaves the table unchanged.
- R7: Two addresses with the same index but different tags do not share an entry. A lookup of one never hits the other's entry.
- R8: A lookup and an update to the same index in the same cycle see the updated entry. The update takes effect first.
- R9: When `resolve_valid`=1 and `resolve_taken` differs from `resolve_pred_taken`, `flush` is 1 in the next cycle. In that same cycle `redirect_addr` is `resolve_target` when the branch was taken, and `resolve_pc`+4 when it was not.
- R10: `flush` is 0 in the cycle after any cycle with no resolve, or with a resolve whose direction matched the prediction.
- R11: A taken resolve that hits its entry replaces the stored target with `resolve_target`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_addr | input | AW | Address being fetched this cycle |
| next_fetch_addr | output | AW | Predicted next fetch address (combinational) |
| pred_taken | output | 1 | Lookup predicts a taken branch |
| resolve_valid | input | 1 | A branch resolves this cycle |
| resolve_pc | input | AW | Address of the resolving branch |
| resolve_taken | input | 1 | Actual direction of the branch |
| resolve_target | input | AW | Actual taken target |
| resolve_pred_taken | input | 1 | Direction that was predicted for this branch |
| flush | output | 1 | One-cycle flush/redirect pulse |
| redirect_addr | output | AW | Correct restart address while `flush` is 1 |

## Verification
The lookup outputs are combinational, so the bench checks `pred_taken` and `next_fetch_addr` in the same cycle it drives the inputs. That sample is taken one time unit after the falling edge, and it already includes any update arriving in that cycle. `flush` and `redirect_addr` pass through one register. The bench therefore keeps the expected values from each cycle's resolve and compares them one clock later, at the next falling-edge sample. Table training becomes visible at the edge that follows a resolve. It is observed through later lookups of the same address, and through the same-cycle bypass.

// File: rtl/bht_predictor.sv
module bht_predictor #(
  parameter int AW      = 32,
  parameter int ENTRIES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] fetch_addr,
  output logic [AW-1:0] next_fetch_addr,
  output logic          pred_taken,
  input  logic          resolve_valid,
  input  logic [AW-1:0] resolve_pc,
  input  logic          resolve_taken,
  input  logic [AW-1:0] resolve_target,
  input  logic          resolve_pred_taken,
  output logic          flush,
  output logic [AW-1:0] redirect_addr
);
  localparam int IDXW = $clog2(ENTRIES);
  localparam int TW   = AW - IDXW - 2;

  logic [ENTRIES-1:0] vld_q;
  logic [TW-1:0]      tag_q [ENTRIES];
  logic [AW-1:0]      tgt_q [ENTRIES];
  logic [1:0]         ctr_q [ENTRIES];

  // update side
  logic [IDXW-1:0] u_idx;
  logic [TW-1:0]   u_tag;
  logic            u_hit, u_we;
  logic [1:0]      u_ctr, u_old;
  logic [AW-1:0]   u_tgt;

  assign u_idx = resolve_pc[IDXW+1:2];
  assign u_tag = resolve_pc[AW-1:IDXW+2];
  assign u_old = ctr_q[u_idx];
  assign u_hit = vld_q[u_idx] && (tag_q[u_idx] == u_tag);
  assign u_we  = resolve_valid && (u_hit || resolve_taken);
  assign u_tgt = resolve_taken ? resolve_target : tgt_q[u_idx];

  always_comb begin
    if (!u_hit)                u_ctr = 2'b10;
    else if (resolve_taken)    u_ctr = (u_old == 2'b11) ? u_old : u_old + 2'b01;
    else                       u_ctr = (u_old == 2'b00) ? u_old : u_old - 2'b01;
  end

  // lookup side, with same-cycle bypass of the update
  logic [IDXW-1:0] f_idx;
  logic [TW-1:0]   f_tag, e_tag;
  logic            byp, e_v, f_hit;
  logic [AW-1:0]   e_tgt;
  logic [1:0]      e_ctr;

  assign f_idx = fetch_addr[IDXW+1:2];
  assign f_tag = fetch_addr[AW-1:IDXW+2];
  assign byp   = u_we && (u_idx == f_idx);
  assign e_v   = byp ? 1'b1  : vld_q[f_idx];
  assign e_tag = byp ? u_tag : tag_q[f_idx];
  assign e_tgt = byp ? u_tgt : tgt_q[f_idx];
  assign e_ctr = byp ? u_ctr : ctr_q[f_idx];
  assign f_hit = e_v && (e_tag == f_tag);

  assign pred_taken      = f_hit && e_ctr[1];
  assign next_fetch_addr = pred_taken ? e_tgt : fetch_addr + AW'(4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        tgt_q[i] <= '0;
        ctr_q[i] <= 2'b00;
      end
    end else if (u_we) begin
      vld_q[u_idx] <= 1'b1;
      tag_q[u_idx] <= u_tag;
      tgt_q[u_idx] <= u_tgt;
      ctr_q[u_idx] <= u_ctr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush         <= 1'b0;
      redirect_addr <= '0;
    end else begin
      flush         <= resolve_valid && (resolve_taken != resolve_pred_taken);
      redirect_addr <= resolve_taken ? resolve_target : resolve_pc + AW'(4);
    end
  end

  // R2
  miss_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_taken |-> next_fetch_addr == fetch_addr + AW'(4));
  // R9
  flush_on_mispredict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_valid && (resolve_taken != resolve_pred_taken) |=> flush);
  // R9
  redirect_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_valid && resolve_taken && !resolve_pred_taken |=> redirect_addr == $past(resolve_target));
  // R10
  no_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resolve_valid |=> !flush);
  // R6
  nt_miss_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_valid && !resolve_taken && !u_hit |=> vld_q == $past(vld_q));
  // R4
  ctr_sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_valid && resolve_taken && u_hit && u_old == 2'b11 |=> ctr_q[$past(u_idx)] == 2'b11);
endmodule

// File: tb/tb_bht_predictor.sv
module tb_bht_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int ENTRIES = 16;
  localparam int IDXW = $clog2(ENTRIES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] fetch_addr = '0, resolve_pc = '0, resolve_target = '0;
  logic resolve_valid = 1'b0, resolve_taken = 1'b0, resolve_pred_taken = 1'b0;
  logic [AW-1:0] next_fetch_addr, redirect_addr;
  logic pred_taken, flush;

  always #(CLK_PERIOD/2) clk = ~clk;

  bht_predictor #(.AW(AW), .ENTRIES(ENTRIES)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr),
    .next_fetch_addr(next_fetch_addr), .pred_taken(pred_taken),
    .resolve_valid(resolve_valid), .resolve_pc(resolve_pc),
    .resolve_taken(resolve_taken), .resolve_target(resolve_target),
    .resolve_pred_taken(resolve_pred_taken),
    .flush(flush), .redirect_addr(redirect_addr));

  int checks = 0, fails = 0;
  bit done = 0;

  bit          m_v   [ENTRIES];
  logic [AW-1:0] m_pc  [ENTRIES];
  logic [AW-1:0] m_tgt [ENTRIES];
  int          m_ctr [ENTRIES];
  bit          exp_fl = 0;
  logic [AW-1:0] exp_rd = '0;

  function automatic int idx_of(logic [AW-1:0] a);
    return int'(a[IDXW+1:2]);
  endfunction

  function automatic bit m_hit(logic [AW-1:0] a);
    int i = idx_of(a);
    return m_v[i] && (m_pc[i][AW-1:IDXW+2] == a[AW-1:IDXW+2]);
  endfunction

  function automatic bit m_pred(logic [AW-1:0] a);
    return m_hit(a) && (m_ctr[idx_of(a)] >= 2);
  endfunction

  function automatic logic [AW-1:0] m_next(logic [AW-1:0] a);
    return m_pred(a) ? m_tgt[idx_of(a)] : a + 32'd4;
  endfunction

  function automatic void m_update(logic [AW-1:0] pc, bit tk, logic [AW-1:0] tg);
    int i = idx_of(pc);
    if (m_hit(pc)) begin
      if (tk) begin
        if (m_ctr[i] < 3) m_ctr[i]++;
        m_tgt[i] = tg;
      end else if (m_ctr[i] > 0) m_ctr[i]--;
    end else if (tk) begin
      m_v[i] = 1; m_pc[i] = pc; m_tgt[i] = tg; m_ctr[i] = 2;
    end
  endfunction

  task automatic check(string r, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic step(logic [AW-1:0] fa, bit rv, logic [AW-1:0] rpc, bit rt,
                      logic [AW-1:0] rtg, bit rpt, string r);
    @(negedge clk);
    fetch_addr = fa; resolve_valid = rv; resolve_pc = rpc;
    resolve_taken = rt; resolve_target = rtg; resolve_pred_taken = rpt;
    #1;
    check(exp_fl ? "R9 flush" : "R10 flush", {31'b0, flush}, {31'b0, exp_fl});
    if (exp_fl) check("R9 redirect", redirect_addr, exp_rd);
    if (rv) m_update(rpc, rt, rtg);
    check({r, " pred"}, {31'b0, pred_taken}, {31'b0, m_pred(fa)});
    check({r, " next"}, next_fetch_addr, m_next(fa));
    exp_fl = rv && (rt != rpt);
    exp_rd = rt ? rtg : rpc + 32'd4;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a, b, c;
    void'($urandom(32'd1234));
    for (int i = 0; i < ENTRIES; i++) begin
      m_v[i] = 0; m_pc[i] = '0; m_tgt[i] = '0; m_ctr[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    a = 32'h0000_0100; b = 32'h0000_0204; c = 32'h0000_0140;
    // R1: empty table after reset
    step(a, 0, '0, 0, '0, 0, "R1");
    step(b, 0, '0, 0, '0, 0, "R1");
    // R6: not-taken miss allocates nothing
    step(b, 1, a, 0, 32'h900, 0, "R6");
    step(a, 0, '0, 0, '0, 0, "R6");
    // R5 + R8: taken miss allocates, seen by the lookup in the same cycle
    step(a, 1, a, 1, 32'h900, 0, "R8");
    step(a, 0, '0, 0, '0, 0, "R5");
    // R4: decrement to 1 -> not taken (mispredict -> R9 redirect to pc+4)
    step(a, 1, a, 0, 32'h900, 1, "R4");
    step(a, 0, '0, 0, '0, 0, "R3");
    // R4: up to saturation
    step(a, 1, a, 1, 32'h900, 0, "R4");
    step(a, 1, a, 1, 32'h900, 1, "R4");
    step(a, 1, a, 1, 32'h900, 1, "R4");
    step(a, 1, a, 0, 32'h900, 1, "R4");
    step(a, 0, '0, 0, '0, 0, "R4");
    // R7: same index, other tag
    step(c, 0, '0, 0, '0, 0, "R7");
    step(b, 1, c, 1, 32'hA00, 0, "R7");
    step(a, 0, '0, 0, '0, 0, "R7");
    step(c, 0, '0, 0, '0, 0, "R7");
    // R11: taken hit refreshes target
    step(b, 1, c, 1, 32'hB00, 1, "R11");
    step(c, 0, '0, 0, '0, 0, "R11");
    // R4: saturate low
    for (int k = 0; k < 4; k++) step(c, 1, c, 0, 32'hB00, 0, "R4");
    step(c, 0, '0, 0, '0, 0, "R4");
    // random mix over a small address pool
    for (int n = 0; n < 1500; n++) begin
      logic [AW-1:0] fa, pc, tg;
      fa = {24'b0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), 2'b00};
      pc = {24'b0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), 2'b00};
      tg = {16'b0, 14'($urandom), 2'b00};
      step(fa, 1'($urandom_range(0, 1)), pc, 1'($urandom_range(0, 1)), tg,
           1'($urandom_range(0, 1)), m_hit(fa) ? "R3" : "R2");
    end
    step(a, 0, '0, 0, '0, 0, "R10");
    step(a, 0, '0, 0, '0, 0, "R10");
    done = 1;
    summary();
    $finish;
  end
endmodule